// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block gathers interrupt requests from a set of peripheral sources and turns them into one request to the processor. The request carries a vector number and a priority level. Each source has an enable bit and a sticky pending flag. It also has a 3-bit priority level, which software programs through a small register port. On every clock edge the block arbitrates among the sources that are both pending and enabled. The highest level wins, and on equal levels the lowest source number wins. The block registers the winner's vector and level onto its outputs.

The processor acknowledges the presented vector with a one-cycle pulse. That pulse clears the pending flag of the presented vector, and the next winner appears after the same clock edge. Sources that lose arbitration stay pending. A source that arrives later with higher priority takes over an outstanding request before it is acknowledged, and the displaced source keeps its pending flag. The processor's own interrupt-level mask is modelled as a threshold input. The request line is raised only when the winner's level is non-zero and not below that threshold.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset all level fields, all enable bits and all pending flags are 0. `irq_req` is low, and `irq_vec`, `irq_lvl` and every register read are 0.
- R2: Level register k (address k, for k < N_SRC/2) holds the level of source 2k in bits 2:0 and the level of source 2k+1 in bits 10:8. Its other bits read 0 and ignore writes. Address N_SRC/2 holds the enable bits, with bit i enabling source i. Any other address reads 0, and writes to it change nothing.
- R3: Among the sources that are both pending and enabled, the one with the highest level is presented on `irq_vec` and `irq_lvl`.
- R4: When several pending enabled sources share the highest level, the lowest source number is presented.
- R5: A source whose enable bit is 0 takes no part in arbitration, but its pending flag is kept. It is presented once it is enabled.
- R6: An `irq_ack` pulse seen with `irq_req` high clears the pending flag of the presented vector. The outputs after that clock edge show the next winner among the remaining sources.
- R7: If a higher-priority source becomes pending while a request is outstanding, the outputs switch to it after that edge. The displaced source stays pending and is presented again after the new one is acknowledged.
- R8: `irq_req` is high only when the winner's level is non-zero and greater than or equal to `cpu_thresh`. When `irq_req` is low, `irq_vec` and `irq_lvl` still show the winner, and `irq_ack` is ignored.
- R9: If a source's `irq_in` bit and the acknowledge of that same source fall in the same cycle, the source stays pending.
- R10: When no enabled source is pending, `irq_req` is low and `irq_vec` and `irq_lvl` are 0.
- R11: Outputs are registered. A change on `irq_in`, `irq_ack`, the registers or `cpu_thresh` first shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_in | input | N_SRC | Per-source request pulses; a 1 sets the pending flag |
| cpu_thresh | input | 3 | Processor interrupt-level threshold |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Presented source number |
| irq_lvl | output | 3 | Level of the presented source |

## Verification
Two functions can fall in the same cycle: the acknowledge that clears a pending flag, and a new request that sets a pending flag. The bench makes them collide on purpose. It drives an `irq_in` bit for the vector being acknowledged, and it also raises higher-priority arrivals during the acknowledge cycle in a long pseudo-random sweep. In each cycle a bench-side model applies "clear, then set", recomputes the winner by scanning levels from 7 downward, and judges the registered outputs against that result.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int LVL_W    = 3;
  localparam int REG_W    = 16;
  localparam int LO_FIELD = 0;   // even source level position
  localparam int HI_FIELD = 8;   // odd source level position

  typedef logic [LVL_W-1:0] lvl_t;

  // candidate replaces the current best only on a strictly higher level,
  // so an ascending scan keeps the lowest index on ties
  function automatic logic lvl_beats(lvl_t cand, lvl_t best, logic have);
    return !have || (cand > best);
  endfunction

  // processor-side acceptance model: level 0 is never delivered
  function automatic logic lvl_deliverable(lvl_t lvl, lvl_t thresh);
    return (lvl != '0) && (lvl >= thresh);
  endfunction
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic [N_SRC-1:0]            en_q,
  output logic [N_SRC-1:0]            en_d,
  output lvl_t [N_SRC-1:0]            lvl_q,
  output lvl_t [N_SRC-1:0]            lvl_d
);
  localparam int N_PAIR  = (N_SRC + 1) / 2;
  localparam int EN_ADDR = N_PAIR;

  logic en_hit;
  assign en_hit = reg_wr && (reg_addr == ADDR_W'(EN_ADDR));
  assign en_d   = en_hit ? reg_wdata[N_SRC-1:0] : en_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    logic hit;
    assign hit = reg_wr && (reg_addr == ADDR_W'(i / 2));
    if ((i % 2) == 0) begin : g_even
      assign lvl_d[i] = hit ? reg_wdata[LO_FIELD +: LVL_W] : lvl_q[i];
    end else begin : g_odd
      assign lvl_d[i] = hit ? reg_wdata[HI_FIELD +: LVL_W] : lvl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < N_PAIR; p++) begin
      if (reg_addr == ADDR_W'(p)) begin
        reg_rdata[LO_FIELD +: LVL_W] = lvl_q[2*p];
        if (2*p + 1 < N_SRC) reg_rdata[HI_FIELD +: LVL_W] = lvl_q[2*p+1];
      end
    end
    if (reg_addr == ADDR_W'(EN_ADDR)) reg_rdata[N_SRC-1:0] = en_q;
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_in,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] pend_d
);
  // set has priority over a same-cycle clear
  assign pend_d = set_in | (pend_q & ~clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 3
) (
  input  logic [N_SRC-1:0] cand,
  input  lvl_t [N_SRC-1:0] lvl,
  output logic             found,
  output logic [VEC_W-1:0] win_vec,
  output lvl_t             win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && lvl_beats(lvl[i], win_lvl, found)) begin
        found   = 1'b1;
        win_vec = VEC_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 4,
  parameter int VEC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [2:0]        cpu_thresh,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [2:0]        irq_lvl
);
  // named internal events
  logic             ack_fire;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] pend_q_w, pend_d_w;
  logic [N_SRC-1:0] en_q_w, en_d_w;
  lvl_t [N_SRC-1:0] lvl_q_w, lvl_d_w;
  logic [N_SRC-1:0] cand_d;
  logic             arb_found;
  logic [VEC_W-1:0] arb_vec;
  lvl_t             arb_lvl;
  logic             req_d;

  assign ack_fire = irq_ack && irq_req;

  always_comb begin
    clr_mask = '0;
    if (ack_fire) clr_mask[irq_vec] = 1'b1;
  end

  irq_lvl_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en_q(en_q_w), .en_d(en_d_w), .lvl_q(lvl_q_w), .lvl_d(lvl_d_w)
  );

  irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_in(irq_in), .clr_mask(clr_mask),
    .pend_q(pend_q_w), .pend_d(pend_d_w)
  );

  // arbitrate over next state so the registered outputs match the state
  assign cand_d = pend_d_w & en_d_w;

  irq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .cand(cand_d), .lvl(lvl_d_w),
    .found(arb_found), .win_vec(arb_vec), .win_lvl(arb_lvl)
  );

  assign req_d = arb_found && lvl_deliverable(arb_lvl, cpu_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else begin
      irq_req <= req_d;
      irq_vec <= arb_found ? arb_vec : '0;
      irq_lvl <= arb_found ? arb_lvl : '0;
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SRC-1:0]       irq_in,
  input logic [2:0]             cpu_thresh,
  input logic                   ack_fire,
  input logic                   irq_req,
  input logic [VEC_W-1:0]       irq_vec,
  input logic [2:0]             irq_lvl,
  input logic [N_SRC-1:0]       pend_q,
  input logic [N_SRC-1:0]       en_q,
  input logic [N_SRC*3-1:0]     lvl_flat
);
  logic better_exists;
  logic any_live;
  logic set_on_vec;

  always_comb begin
    better_exists = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_q[i] && en_q[i]) begin
        if (lvl_flat[i*3 +: 3] > irq_lvl) better_exists = 1'b1;
        if (lvl_flat[i*3 +: 3] == irq_lvl && i < int'(irq_vec)) better_exists = 1'b1;
      end
    end
  end

  assign any_live   = |(pend_q & en_q);
  assign set_on_vec = irq_in[irq_vec];

  AST_REQ_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[irq_vec] && en_q[irq_vec]));            // R5
  AST_REQ_IS_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !better_exists);                                  // R3
  AST_REQ_LVL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != 3'd0));                               // R8
  AST_REQ_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (irq_lvl >= $past(cpu_thresh)));           // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !set_on_vec) |=> !pend_q[$past(irq_vec)]);       // R6
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && set_on_vec) |=> pend_q[$past(irq_vec)]);         // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_live |-> (!irq_req && irq_lvl == 3'd0));                 // R10
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_thresh(cpu_thresh),
  .ack_fire(ack_fire), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .pend_q(pend_q_w), .en_q(en_q_w), .lvl_flat(lvl_q_w)
);

// File: tb/irq_level_ctrl_test.sv
`timescale 1ns/1ps
module irq_level_ctrl_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic [2:0]  cpu_thresh = '0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_vec;
  logic [2:0]  irq_lvl;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_level_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .cpu_thresh(cpu_thresh), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  // bench model
  bit [N-1:0] m_pend = '0;
  bit [N-1:0] m_en = '0;
  bit [2:0]   m_lvl [N];
  bit         e_req = 1'b0;
  bit [2:0]   e_vec = '0;
  bit [2:0]   e_lvl = '0;
  bit [31:0]  rng = 32'h1234_5678;

  function automatic bit [31:0] next_rng(bit [31:0] s);
    bit [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // winner: scan levels from 7 down, first source index at that level
  task automatic model_arb(bit [2:0] th);
    bit found = 1'b0;
    e_vec = '0;
    e_lvl = '0;
    for (int l = 7; l >= 0; l--) begin
      for (int i = 0; i < N; i++) begin
        if (!found && m_pend[i] && m_en[i] && int'(m_lvl[i]) == l) begin
          found = 1'b1;
          e_vec = 3'(i);
          e_lvl = 3'(l);
        end
      end
    end
    e_req = found && (e_lvl != 0) && (e_lvl >= th);
  endtask

  task automatic check_out(string tag);
    check({irq_req, irq_vec, irq_lvl} === {e_req, e_vec, e_lvl}, tag,
          int'({irq_req, irq_vec, irq_lvl}), int'({e_req, e_vec, e_lvl}));
  endtask

  // one clock: drive at negedge, update model at the edge, check at next negedge
  task automatic step(bit [N-1:0] set, bit ack, bit [2:0] th, bit wr,
                      bit [3:0] a, bit [15:0] d, string tag);
    irq_in = set; irq_ack = ack; cpu_thresh = th;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (ack && e_req) m_pend[e_vec] = 1'b0;
    m_pend = m_pend | set;
    if (wr) begin
      if (a < 4) begin
        m_lvl[2*a]   = d[2:0];
        m_lvl[2*a+1] = d[10:8];
      end else if (a == 4) begin
        m_en = d[7:0];
      end
    end
    model_arb(th);
    @(negedge clk);
    irq_in = '0; irq_ack = 1'b0; reg_wr = 1'b0;
    check_out(tag);
  endtask

  task automatic rd_chk(bit [3:0] a, bit [15:0] exp, string tag);
    reg_addr = a;
    #0.5;
    check(reg_rdata === exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic idle(string tag);
    step('0, 1'b0, cpu_thresh, 1'b0, 4'd0, 16'd0, tag);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_lvl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({irq_req, irq_vec, irq_lvl} === 7'd0, "R1 outputs in reset", int'({irq_req, irq_vec, irq_lvl}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release");
    for (int a = 0; a < 6; a++) rd_chk(4'(a), 16'h0000, "R1 reg reset");

    // R2: register layout, reserved bits
    step('0, 0, 0, 1, 4'd0, 16'hFFFF, "R2 write lvl0");
    rd_chk(4'd0, 16'h0707, "R2 reserved bits read 0");
    step('0, 0, 0, 1, 4'd1, 16'h0503, "R2 write lvl1");
    rd_chk(4'd1, 16'h0503, "R2 fields 2:0 and 10:8");
    step('0, 0, 0, 1, 4'd4, 16'hFFFF, "R2 write enables");
    rd_chk(4'd4, 16'h00FF, "R2 enable reg");
    step('0, 0, 0, 1, 4'd9, 16'hFFFF, "R2 write unmapped");
    rd_chk(4'd9, 16'h0000, "R2 unmapped reads 0");
    rd_chk(4'd0, 16'h0707, "R2 unmapped write no effect");
    // levels: src0..7 = 2,5,5,1,7,3,0,4
    step('0, 0, 0, 1, 4'd0, 16'h0502, "R2 prog");
    step('0, 0, 0, 1, 4'd1, 16'h0105, "R2 prog");
    step('0, 0, 0, 1, 4'd2, 16'h0307, "R2 prog");
    step('0, 0, 0, 1, 4'd3, 16'h0400, "R2 prog");
    rd_chk(4'd2, 16'h0307, "R2 readback");

    // R11: no output change before the edge
    irq_in = 8'h01;
    #1;
    check(irq_req === 1'b0, "R11 registered output", int'(irq_req), 0);
    step(8'h01, 0, 0, 0, 4'd0, 16'd0, "R11 after edge");
    // R3: highest level
    step(8'h08, 0, 0, 0, 4'd0, 16'd0, "R3 lvl2 beats lvl1");
    // R4: ties
    step(8'h06, 0, 0, 0, 4'd0, 16'd0, "R4 tie lowest vector");
    // R6: drain in order 1,2,0,3
    step('0, 1, 0, 0, 4'd0, 16'd0, "R6 next after ack");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R6 next after ack");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R6 next after ack");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R10 empty after last ack");
    idle("R10 stays idle");
    // R7: retarget then return
    step(8'h08, 0, 0, 0, 4'd0, 16'd0, "R7 low request");
    step(8'h10, 0, 0, 0, 4'd0, 16'd0, "R7 retarget to higher");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R7 displaced presented again");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R10 drained");
    // R5: disabled source ignored but kept
    step('0, 0, 0, 1, 4'd4, 16'h00EF, "R5 disable src4");
    step(8'h11, 0, 0, 0, 4'd0, 16'd0, "R5 disabled not chosen");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R5 only disabled left");
    step('0, 0, 0, 1, 4'd4, 16'h00FF, "R5 enabled shows kept pending");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R5 drained");
    // R8: threshold and level 0
    step(8'h01, 0, 3'd5, 0, 4'd0, 16'd0, "R8 below threshold");
    step('0, 1, 3'd5, 0, 4'd0, 16'd0, "R8 ack ignored when no req");
    step('0, 0, 3'd2, 0, 4'd0, 16'd0, "R8 equal threshold accepted");
    // R9: set and ack same source
    step(8'h01, 1, 3'd2, 0, 4'd0, 16'd0, "R9 set wins over ack");
    step('0, 1, 3'd0, 0, 4'd0, 16'd0, "R9 then cleared");
    step(8'h40, 0, 3'd0, 0, 4'd0, 16'd0, "R8 level 0 never requests");
    step('0, 0, 0, 1, 4'd3, 16'h0401, "R8 raise level of src6");
    step('0, 1, 0, 0, 4'd0, 16'd0, "R6 clear src6");

    // sweep: collisions of set and ack, threshold and level changes
    for (int n = 0; n < 4000; n++) begin
      bit [N-1:0] s;
      bit ak, wr;
      bit [3:0] a;
      bit [2:0] th;
      rng = next_rng(rng);
      s  = rng[7:0] & rng[15:8] & rng[23:16];
      ak = rng[24] | rng[25];
      th = (rng[31:29] == 3'd0) ? 3'(rng[28:26]) : cpu_thresh;
      rng = next_rng(rng);
      wr = (rng[5:0] == 6'd0);
      a  = (rng[7:6] == 2'd0) ? 4'd4 : {2'b00, rng[9:8]};
      step(s, ak, th, wr, a, (a == 4) ? (rng[31:16] | 16'h00C0) : rng[31:16],
           "R3 R4 R7 R9 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule